// File: doc/BRIEF.md
# Semi-Digital Hit Frame Buffer

This block sits behind the comparators of a multi-channel pad readout where every channel has three discriminators set at rising thresholds. Each clock, the three comparator bits of every channel are folded into a 2-bit level code. During an acquisition phase, any cycle in which at least one channel shows a non-zero code causes the whole set of codes to be written, together with the current value of a bunch-crossing counter, into one entry of a frame memory. No external trigger is involved: the channels trigger the capture themselves.

Acquisition windows are short and are separated by long quiet periods. In a quiet period the stored frames are streamed out one bit per clock on a serial pin. Several chips share one data line and one token path. Each chip passes the upstream serial line through while it is silent, shifts its own frames when the token reaches it, and then hands the token to the next chip.

Top module: `hit_frame_buffer`

## Requirements
- R1: Channel c drives disc bits [3c+2:3c] as {high, mid, low} and its code occupies frame bits [2c+1:2c]. 000 gives code 00, 001 gives 01, 011 gives 10, and 111 gives 11. Every pattern that is not a thermometer pattern (010, 100, 101, 110) gives 11.
- R2: On a clock edge where acqEn is high and at least one channel code is non-zero, exactly one frame is stored. A hit sampled on the last acquisition cycle is stored. Hits while acqEn is low are not stored, and neither are acquisition cycles where every code is zero.
- R3: The timestamp counter reads 0 on the first edge at which acqEn is high and rises by one on each following edge while acqEn stays high. It is cleared while acqEn is low. A frame records the counter value at its capture edge.
- R4: A frame is {timestamp, code of channel NUM_CH-1, ..., code of channel 0} and is shifted MSB first. The first bit appears on serOut right after the edge that samples tokenIn high with acqEn low, and each following edge presents the next bit.
- R5: Frames are sent oldest first, back to back, with no gap cycles between them.
- R6: Once DEPTH frames are held, fullFlag is high and further hits are dropped. The first DEPTH frames are kept intact. fullFlag clears when readout of the memory completes.
- R7: tokenOut is high for exactly one cycle: the cycle after the last bit has been presented, or the cycle right after the start edge if the memory is empty.
- R8: When the block is not shifting, serOut follows serIn.
- R9: tokenIn is ignored while acqEn is high.
- R10: After reset, fullFlag and tokenOut are low and the memory is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| acqEn | input | 1 | High during the acquisition phase |
| disc | input | 3*NUM_CH | Comparator outputs, three per channel |
| tokenIn | input | 1 | Readout token from the previous chip |
| serIn | input | 1 | Serial data from the upstream chip |
| serOut | output | 1 | Serial data toward the downstream chip |
| tokenOut | output | 1 | One-cycle token to the next chip |
| fullFlag | output | 1 | Memory holds DEPTH frames |

## Verification
The bench builds the block with NUM_CH=4, DEPTH=4 and TS_W=8. This gives a 16-bit frame and a four-entry memory. With these values the full condition can be reached after four hits and the overflow behaviour checked after six. The complete serial stream of every capture round is short enough to be compared bit for bit. Four channels are still enough to place each of the eight comparator patterns on different channels across the table vectors.

// File: rtl/hfb_pkg.sv
package hfb_pkg;

  typedef struct packed {
    logic capture;
    logic loadFrame;
    logic shiftBit;
  } hfb_strobe_t;

  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_SHIFT = 2'd1,
    RD_DONE  = 2'd2
  } hfb_rd_state_e;

  // three comparator bits {high, mid, low} to a level code
  function automatic logic [1:0] levelCode(input logic [2:0] t);
    case (t)
      3'b000:  levelCode = 2'b00;
      3'b001:  levelCode = 2'b01;
      3'b011:  levelCode = 2'b10;
      default: levelCode = 2'b11; // full set and any broken pattern
    endcase
  endfunction

endpackage

// File: rtl/hfb_encoder.sv
module hfb_encoder #(
  parameter int NUM_CH = 64
) (
  input  logic [3*NUM_CH-1:0] disc,
  output logic [2*NUM_CH-1:0] codes,
  output logic                anyHit
);
  import hfb_pkg::*;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    assign codes[2*ch +: 2] = levelCode(disc[3*ch +: 3]);
  end

  assign anyHit = |codes;

endmodule

// File: rtl/hfb_datapath.sv
module hfb_datapath #(
  parameter int NUM_CH = 64,
  parameter int DEPTH  = 128,
  parameter int TS_W   = 24,
  localparam int AW    = $clog2(DEPTH),
  localparam int FW    = TS_W + 2*NUM_CH
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                acqEn,
  input  logic [3*NUM_CH-1:0] disc,
  input  hfb_pkg::hfb_strobe_t strb,
  input  logic [AW-1:0]       wrAddr,
  input  logic [AW-1:0]       rdAddr,
  output logic                anyHit,
  output logic                serBit
);
  logic [2*NUM_CH-1:0] codes;
  logic [TS_W-1:0]     tsCnt;
  logic [FW-1:0]       frameMem [DEPTH];
  logic [FW-1:0]       shReg;

  hfb_encoder #(.NUM_CH(NUM_CH)) u_enc (
    .disc   (disc),
    .codes  (codes),
    .anyHit (anyHit)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      tsCnt <= '0;
    else if (!acqEn) tsCnt <= '0;
    else            tsCnt <= tsCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strb.capture) frameMem[wrAddr] <= {tsCnt, codes};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              shReg <= '0;
    else if (strb.loadFrame) shReg <= frameMem[rdAddr];
    else if (strb.shiftBit)  shReg <= {shReg[FW-2:0], 1'b0};
  end

  assign serBit = shReg[FW-1];

  // R3
  ts_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !acqEn |=> (tsCnt == '0));

  // R3
  ts_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    acqEn |=> (tsCnt == $past(tsCnt) + 1'b1));

endmodule

// File: rtl/hfb_ctrl.sv
module hfb_ctrl #(
  parameter int DEPTH = 128,
  parameter int FW    = 152,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int BW   = $clog2(FW)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 acqEn,
  input  logic                 anyHit,
  input  logic                 tokenIn,
  output hfb_pkg::hfb_strobe_t strb,
  output logic [AW-1:0]        wrAddr,
  output logic [AW-1:0]        rdAddr,
  output logic                 fullFlag,
  output logic                 tokenOut,
  output logic                 shifting
);
  import hfb_pkg::*;

  hfb_rd_state_e state;
  logic [CW-1:0] count;
  logic [AW-1:0] rdPtr;
  logic [BW-1:0] bitCnt;
  logic          startRd, lastBit, lastFrame, isEmpty;

  assign fullFlag  = (count == CW'(DEPTH));
  assign isEmpty   = (count == '0);
  assign startRd   = (state == RD_IDLE) && tokenIn && !acqEn;
  assign lastBit   = (bitCnt == '0);
  assign lastFrame = ((CW'(rdPtr) + CW'(1)) == count);

  always_comb begin
    strb           = '0;
    strb.capture   = (state == RD_IDLE) && acqEn && anyHit && !fullFlag;
    strb.loadFrame = (startRd && !isEmpty) ||
                     ((state == RD_SHIFT) && lastBit && !lastFrame);
    strb.shiftBit  = (state == RD_SHIFT) && !lastBit;
  end

  assign wrAddr   = AW'(count);
  assign rdAddr   = (state == RD_SHIFT) ? rdPtr + 1'b1 : '0;
  assign tokenOut = (state == RD_DONE);
  assign shifting = (state == RD_SHIFT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= RD_IDLE;
      count  <= '0;
      rdPtr  <= '0;
      bitCnt <= '0;
    end else begin
      case (state)
        RD_IDLE: begin
          if (strb.capture) count <= count + 1'b1;
          if (startRd) begin
            state  <= isEmpty ? RD_DONE : RD_SHIFT;
            rdPtr  <= '0;
            bitCnt <= BW'(FW - 1);
          end
        end
        RD_SHIFT: begin
          if (!lastBit) begin
            bitCnt <= bitCnt - 1'b1;
          end else if (lastFrame) begin
            state <= RD_DONE;
            count <= '0;
            rdPtr <= '0;
          end else begin
            rdPtr  <= rdPtr + 1'b1;
            bitCnt <= BW'(FW - 1);
          end
        end
        default: state <= RD_IDLE;
      endcase
    end
  end

  // R6
  full_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fullFlag && state == RD_IDLE && !tokenIn) |=> fullFlag);

  // R7
  token_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    tokenOut |=> !tokenOut);

  // R4
  shift_nonempty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == RD_SHIFT) |-> (count != '0));

  // R9
  token_ignored_acq_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((state == RD_IDLE) && acqEn) |=> (state == RD_IDLE));

endmodule

// File: rtl/hit_frame_buffer.sv
module hit_frame_buffer #(
  parameter int NUM_CH = 64,
  parameter int DEPTH  = 128,
  parameter int TS_W   = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                acqEn,
  input  logic [3*NUM_CH-1:0] disc,
  input  logic                tokenIn,
  input  logic                serIn,
  output logic                serOut,
  output logic                tokenOut,
  output logic                fullFlag
);
  import hfb_pkg::*;

  localparam int AW = $clog2(DEPTH);
  localparam int FW = TS_W + 2*NUM_CH;

  hfb_strobe_t   strb;
  logic [AW-1:0] wrAddr, rdAddr;
  logic          anyHit, serBit, shifting;

  hfb_ctrl #(.DEPTH(DEPTH), .FW(FW)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .acqEn    (acqEn),
    .anyHit   (anyHit),
    .tokenIn  (tokenIn),
    .strb     (strb),
    .wrAddr   (wrAddr),
    .rdAddr   (rdAddr),
    .fullFlag (fullFlag),
    .tokenOut (tokenOut),
    .shifting (shifting)
  );

  hfb_datapath #(.NUM_CH(NUM_CH), .DEPTH(DEPTH), .TS_W(TS_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .acqEn  (acqEn),
    .disc   (disc),
    .strb   (strb),
    .wrAddr (wrAddr),
    .rdAddr (rdAddr),
    .anyHit (anyHit),
    .serBit (serBit)
  );

  assign serOut = shifting ? serBit : serIn;

endmodule

// File: tb/hit_frame_buffer_test.sv
module hit_frame_buffer_test;
  localparam int NUM_CH = 4;
  localparam int DEPTH  = 4;
  localparam int TS_W   = 8;
  localparam int FW     = TS_W + 2*NUM_CH;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                acqEn = 1'b0;
  logic [3*NUM_CH-1:0] disc = '0;
  logic                tokenIn = 1'b0;
  logic                serIn = 1'b0;
  logic                serOut, tokenOut, fullFlag;

  int nChecks = 0;
  int nFails  = 0;
  logic [TS_W-1:0]     expTs   [DEPTH];
  logic [2*NUM_CH-1:0] expCode [DEPTH];

  // {disc pattern, expected codes}
  localparam logic [19:0] VEC [8] = '{
    {12'h001, 8'h01}, {12'h018, 8'h08}, {12'h1C0, 8'h30}, {12'h207, 8'h43},
    {12'h002, 8'h03}, {12'h020, 8'h0C}, {12'hD40, 8'hF0}, {12'h6DB, 8'hAA}
  };

  always #4 clk = ~clk;

  hit_frame_buffer #(.NUM_CH(NUM_CH), .DEPTH(DEPTH), .TS_W(TS_W)) uut (
    .clk(clk), .rstN(rstN), .acqEn(acqEn), .disc(disc), .tokenIn(tokenIn),
    .serIn(serIn), .serOut(serOut), .tokenOut(tokenOut), .fullFlag(fullFlag)
  );

  task automatic check(input logic ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R4 R5 R7: token start, stream compare, token handoff
  task automatic readout(input int nFrames);
    logic [FW-1:0] got;
    @(negedge clk); tokenIn = 1'b1; serIn = 1'b1;
    @(negedge clk); tokenIn = 1'b0;
    for (int f = 0; f < nFrames; f++) begin
      got = '0;
      for (int b = 0; b < FW; b++) begin
        got = {got[FW-2:0], serOut};
        if (b == 3) check(tokenOut == 1'b0, "R7 no early token", tokenOut, 0);
        @(negedge clk);
      end
      check(got[FW-1 -: TS_W] == expTs[f], "R3/R5 frame timestamp",
            got[FW-1 -: TS_W], expTs[f]);
      check(got[2*NUM_CH-1:0] == expCode[f], "R1/R4 frame codes",
            got[2*NUM_CH-1:0], expCode[f]);
    end
    check(tokenOut == 1'b1, "R7 token after last bit", tokenOut, 1);
    @(negedge clk);
    check(tokenOut == 1'b0, "R7 token one cycle", tokenOut, 0);
    check(fullFlag == 1'b0, "R6 full cleared by readout", fullFlag, 0);
    serIn = 1'b0;
    #1 check(serOut == 1'b0, "R8 pass-through low", serOut, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    int cyc;
    // R10 reset state
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    serIn = 1'b1;
    @(negedge clk);
    check(fullFlag == 1'b0, "R10 full low", fullFlag, 0);
    check(tokenOut == 1'b0, "R10 token low", tokenOut, 0);
    check(serOut == 1'b1, "R8 pass-through high", serOut, 1);
    readout(0); // R10 memory empty, R7 immediate token

    // table walk: two rounds of four frames with growing gaps
    for (int r = 0; r < 2; r++) begin
      acqEn = 1'b1;
      cyc = 0;
      for (int k = 0; k < DEPTH; k++) begin
        for (int g = 0; g < k; g++) begin
          disc = '0;
          @(negedge clk); cyc++;
        end
        disc = VEC[4*r + k][19:8];
        expTs[k] = TS_W'(cyc);
        expCode[k] = VEC[4*r + k][7:0];
        @(negedge clk); cyc++;
      end
      acqEn = 1'b0; // R2 last-cycle hit above is stored
      disc = '0;
      check(fullFlag == 1'b1, "R6 full after DEPTH hits", fullFlag, 1);
      readout(DEPTH);
    end

    // R2: hits outside acquisition and empty acquisition cycles are not stored
    disc = 12'h6DB;
    repeat (3) @(negedge clk);
    disc = '0;
    acqEn = 1'b1;
    tokenIn = 1'b1; // R9 ignored during acquisition
    repeat (3) @(negedge clk);
    check(tokenOut == 1'b0, "R9 token ignored in acq", tokenOut, 0);
    check(serOut == serIn, "R9/R8 no shift in acq", serOut, serIn);
    tokenIn = 1'b0;
    acqEn = 1'b0;
    check(fullFlag == 1'b0, "R2 nothing stored", fullFlag, 0);
    readout(0);

    // R6 overflow: six hits, first four kept
    acqEn = 1'b1;
    disc = 12'h6DB;
    for (int k = 0; k < 6; k++) begin
      if (k < DEPTH) begin
        expTs[k] = TS_W'(k);
        expCode[k] = 8'hAA;
      end
      if (k == DEPTH - 1) disc = 12'h207;
      if (k == DEPTH - 1) expCode[k] = 8'h43;
      if (k == DEPTH) disc = 12'h001;
      @(negedge clk);
      if (k == DEPTH - 2) check(fullFlag == 1'b0, "R6 not full early", fullFlag, 0);
    end
    check(fullFlag == 1'b1, "R6 full held on overflow", fullFlag, 1);
    acqEn = 1'b0;
    disc = '0;
    readout(DEPTH);

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule